// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a bank of binary semaphore flags shared between two independent processor ports, called left and right. Software on either side uses the flags to pass tokens for shared resources. A side asks for a token by writing a 0 to a flag. It then reads the flag back to learn whether the token is now its own.

Each flag keeps one request latch per side. A resolver stage grants the token to the requesting side. When the owner gives the token back, the resolver hands it to a request that is still waiting. A request that arrives while the flag is owned is not lost: it waits in its latch until the owner releases.

Each port has a capture register for reads. The value it returns stays fixed for as long as the read strobes stay asserted, so a write from the other side cannot change it in the middle of a read.

The design is fully synchronous to one clock. Each port gives one strobe set per cycle. A port writes in a cycle when its select and write strobe are both high. A port reads in a cycle when its select and output enable are high and its write strobe is low.

Top module: `dpsem_unit`

## Requirements
- R1: There are eight flags. Only address bits [2:0] choose the flag, and the upper address bits have no effect. A port does nothing unless its select is high.
- R2: On a write, data bit 0 = 0 requests the token and bit 0 = 1 releases it. Data bits [7:1] have no effect.
- R3: A read returns 8'h00 when the reading side owns the flag and 8'hFF otherwise, with the read-valid output high.
- R4: A request on a free flag gives the token to the requesting side, which then reads 8'h00. The other side reads 8'hFF.
- R5: A request from the side that is locked out stays pending. When the owner releases, the token passes to the pending side, which then reads 8'h00.
- R6: A release with no request pending leaves the flag free, and both sides then read 8'hFF.
- R7: A side with a pending request that writes a 1 withdraws the request. A later release by the owner then leaves the flag free.
- R8: When both sides request the same free flag in the same cycle, the left side wins and the right request stays pending.
- R9: The read value is sampled on the first cycle of a read and appears on the outputs one cycle later. It then stays unchanged while the read is held, even if the flag changes owner.
- R10: When a port is not reading, its data output is 8'hFF and its read-valid output is low, one cycle after the read ends. A cycle with the write strobe high is not a read.
- R11: Synchronous reset frees every flag. Writing 1 from both sides to every flag also leaves all flags free.
- R12: An owner keeps the token until it writes 1 itself. Writes of either value from the other side do not take the token away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 12 | Left address; bits [2:0] pick the flag |
| l_wdata | input | 8 | Left write data; only bit 0 is used |
| l_rdata | output | 8 | Left captured read data |
| l_rvalid | output | 1 | Left read data valid |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 12 | Right address; bits [2:0] pick the flag |
| r_wdata | input | 8 | Right write data; only bit 0 is used |
| r_rdata | output | 8 | Right captured read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The checker assumes each port issues at most one operation per cycle. It also assumes every strobe has a known value on each rising clock edge once reset is released. The bench meets both assumptions by driving all strobes from tasks on the falling edge only. Every write is a single-cycle pulse. Each read is followed by at least one idle cycle, unless the scenario deliberately keeps the read held to test capture freezing. Same-cycle contention is produced only by the one task that drives both ports together.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpsem_port_dec.sv
// Turns one port's strobes into one-hot request-set and request-clear vectors.
module dpsem_port_dec #(
  parameter int NUM_FLAGS = 8,
  parameter int FLAG_AW   = $clog2(NUM_FLAGS)
) (
  input  logic                 sel,
  input  logic                 wr,
  input  logic [FLAG_AW-1:0]   fidx,
  input  logic                 dbit,
  output logic [NUM_FLAGS-1:0] set_v,
  output logic [NUM_FLAGS-1:0] clr_v
);
  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (sel && wr) begin
      set_v[fidx] = ~dbit;
      clr_v[fidx] = dbit;
    end
  end
endmodule

// File: rtl/dpsem_flag_cell.sv
// One flag: a request latch for each side plus the registered owner.
module dpsem_flag_cell
  import dpsem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_l,
  input  logic clr_l,
  input  logic set_r,
  input  logic clr_r,
  output logic want_l,
  output logic want_r,
  output logic own_l,
  output logic own_r
);
  logic   nxt_l, nxt_r;
  owner_e owner_q, owner_d;

  always_comb begin
    nxt_l = set_l ? 1'b1 : (clr_l ? 1'b0 : want_l);
    nxt_r = set_r ? 1'b1 : (clr_r ? 1'b0 : want_r);
    unique case (owner_q)
      OWN_LEFT:  owner_d = nxt_l ? OWN_LEFT  : (nxt_r ? OWN_RIGHT : OWN_NONE);
      OWN_RIGHT: owner_d = nxt_r ? OWN_RIGHT : (nxt_l ? OWN_LEFT  : OWN_NONE);
      default:   owner_d = nxt_l ? OWN_LEFT  : (nxt_r ? OWN_RIGHT : OWN_NONE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      want_l  <= 1'b0;
      want_r  <= 1'b0;
      owner_q <= OWN_NONE;
    end else begin
      want_l  <= nxt_l;
      want_r  <= nxt_r;
      owner_q <= owner_d;
    end
  end

  assign own_l = (owner_q == OWN_LEFT);
  assign own_r = (owner_q == OWN_RIGHT);
endmodule

// File: rtl/dpsem_read_cap.sv
// Per-port read capture: samples on the first read cycle and holds while the read lasts.
module dpsem_read_cap #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  parameter int FLAG_AW   = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 wr,
  input  logic                 oe,
  input  logic [FLAG_AW-1:0]   fidx,
  input  logic [NUM_FLAGS-1:0] own_v,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid
);
  logic window, window_q, held;

  assign window = sel && oe && !wr;
  assign held   = own_v[fidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      window_q <= 1'b0;
      rvalid   <= 1'b0;
      rdata    <= '1;
    end else begin
      window_q <= window;
      rvalid   <= window;
      if (!window)
        rdata <= '1;
      else if (!window_q)
        rdata <= {DATA_W{~held}};
    end
  end
endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  localparam int FLAG_AW = $clog2(NUM_FLAGS);

  logic [FLAG_AW-1:0]   l_fidx, r_fidx;
  logic [NUM_FLAGS-1:0] set_l, clr_l, set_r, clr_r;
  logic [NUM_FLAGS-1:0] want_l, want_r, own_l, own_r;
  logic                 unused_hi;

  assign l_fidx    = l_addr[FLAG_AW-1:0];
  assign r_fidx    = r_addr[FLAG_AW-1:0];
  assign unused_hi = ^{l_addr[ADDR_W-1:FLAG_AW], r_addr[ADDR_W-1:FLAG_AW],
                       l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  dpsem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .sel(l_sel), .wr(l_wr), .fidx(l_fidx), .dbit(l_wdata[0]),
    .set_v(set_l), .clr_v(clr_l)
  );

  dpsem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .sel(r_sel), .wr(r_wr), .fidx(r_fidx), .dbit(r_wdata[0]),
    .set_v(set_r), .clr_v(clr_r)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    dpsem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .set_l(set_l[g]), .clr_l(clr_l[g]),
      .set_r(set_r[g]), .clr_r(clr_r[g]),
      .want_l(want_l[g]), .want_r(want_r[g]),
      .own_l(own_l[g]), .own_r(own_r[g])
    );
  end

  dpsem_read_cap #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .sel(l_sel), .wr(l_wr), .oe(l_oe),
    .fidx(l_fidx), .own_v(own_l), .rdata(l_rdata), .rvalid(l_rvalid)
  );

  dpsem_read_cap #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .sel(r_sel), .wr(r_wr), .oe(r_oe),
    .fidx(r_fidx), .own_v(own_r), .rdata(r_rdata), .rvalid(r_rvalid)
  );
endmodule

// File: rtl/dpsem_unit_chk.sv
module dpsem_unit_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_FLAGS-1:0] want_l,
  input logic [NUM_FLAGS-1:0] want_r,
  input logic [NUM_FLAGS-1:0] own_l,
  input logic [NUM_FLAGS-1:0] own_r,
  input logic [DATA_W-1:0]    l_rdata,
  input logic                 l_rvalid,
  input logic [DATA_W-1:0]    r_rdata,
  input logic                 r_rvalid
);
  // R4
  own_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((own_l & ~want_l) == '0) && ((own_r & ~want_r) == '0));

  // R5
  no_stranded_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((want_l | want_r) & ~(own_l | own_r)) == '0);

  // R12
  keep_token_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(own_l) & ~own_l) & want_l) == '0) &&
    ((($past(own_r) & ~own_r) & want_r) == '0));

  // R9
  l_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    l_rvalid && $past(l_rvalid) |-> $stable(l_rdata));

  // R9
  r_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    r_rvalid && $past(r_rvalid) |-> $stable(r_rdata));

  // R3
  uniform_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_rvalid || l_rdata == '0 || l_rdata == '1) &&
    (!r_rvalid || r_rdata == '0 || r_rdata == '1));

  // R10
  idle_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (l_rvalid || l_rdata == '1) && (r_rvalid || r_rdata == '1));

  // R11
  reset_free_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (own_l == '0) && (own_r == '0));
endmodule

bind dpsem_unit dpsem_unit_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .want_l(want_l), .want_r(want_r), .own_l(own_l), .own_r(own_r),
  .l_rdata(l_rdata), .l_rvalid(l_rvalid), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
);

// File: tb/dpsem_unit_bench.sv
module dpsem_unit_bench;
  localparam bit L = 1'b0;
  localparam bit R = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_wr = 0, l_oe = 0, r_sel = 0, r_wr = 0, r_oe = 0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_rvalid, r_rvalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dpsem_unit u_dpsem_unit (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit side, input logic s, w, o,
                       input logic [11:0] a, input logic [7:0] d);
    if (side == L) begin
      l_sel = s; l_wr = w; l_oe = o; l_addr = a; l_wdata = d;
    end else begin
      r_sel = s; r_wr = w; r_oe = o; r_addr = a; r_wdata = d;
    end
  endtask

  task automatic sem_write(input bit side, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk) drive(side, 1, 1, 0, a, d);
    @(negedge clk) drive(side, 0, 0, 0, '0, '0);
  endtask

  task automatic sem_read(input bit side, input logic [11:0] a,
                          output logic [7:0] v, output logic vld);
    @(negedge clk) drive(side, 1, 0, 1, a, '0);
    @(negedge clk);
    v   = (side == L) ? l_rdata : r_rdata;
    vld = (side == L) ? l_rvalid : r_rvalid;
    drive(side, 0, 0, 0, '0, '0);
    @(negedge clk);
  endtask

  task automatic expect_flag(input string req, input bit side,
                             input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] v;
    logic vld;
    sem_read(side, a, v, vld);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R10 reset l_rvalid", {7'd0, l_rvalid}, 8'h00);
    chk("R10 reset r_rdata", r_rdata, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      expect_flag("R11 reset left free", L, 12'(i), 8'hFF);
      expect_flag("R11 reset right free", R, 12'(i), 8'hFF);
    end
  endtask

  task automatic t_claim;
    logic [7:0] v;
    logic vld;
    sem_write(L, 12'hA41, 8'h00);
    sem_read(L, 12'h001, v, vld);
    chk("R4 left owns after request", v, 8'h00);
    chk("R3 read valid", {7'd0, vld}, 8'h01);
    expect_flag("R4 right locked out", R, 12'h001, 8'hFF);
    expect_flag("R1 high address bits ignored", L, 12'hFF9, 8'h00);
    sem_write(L, 12'h001, 8'h01);
    expect_flag("R6 released flag free (left)", L, 12'h001, 8'hFF);
    expect_flag("R6 released flag free (right)", R, 12'h001, 8'hFF);
  endtask

  task automatic t_data_bits;
    sem_write(R, 12'h005, 8'hFE);
    expect_flag("R2 bits 7:1 set still request", R, 12'h005, 8'h00);
    sem_write(R, 12'h005, 8'h01);
    expect_flag("R2 bit0 one releases", R, 12'h005, 8'hFF);
    @(negedge clk) drive(L, 0, 1, 0, 12'h005, 8'h00);
    @(negedge clk) drive(L, 0, 0, 0, '0, '0);
    expect_flag("R1 write without select ignored", L, 12'h005, 8'hFF);
  endtask

  task automatic t_handover;
    sem_write(R, 12'h002, 8'h00);
    sem_write(L, 12'h002, 8'h00);
    expect_flag("R5 pending left reads one", L, 12'h002, 8'hFF);
    expect_flag("R5 right still owner", R, 12'h002, 8'h00);
    sem_write(R, 12'h002, 8'h01);
    expect_flag("R5 token passed to left", L, 12'h002, 8'h00);
    expect_flag("R5 right now locked out", R, 12'h002, 8'hFF);
    sem_write(L, 12'h002, 8'h01);
    expect_flag("R6 free after last release", R, 12'h002, 8'hFF);
  endtask

  task automatic t_withdraw;
    sem_write(L, 12'h007, 8'h00);
    sem_write(R, 12'h007, 8'h00);
    sem_write(R, 12'h007, 8'h01);
    sem_write(L, 12'h007, 8'h01);
    expect_flag("R7 withdrawn request not granted", R, 12'h007, 8'hFF);
    expect_flag("R7 flag free for left", L, 12'h007, 8'hFF);
  endtask

  task automatic t_keep;
    sem_write(L, 12'h000, 8'h00);
    sem_write(R, 12'h000, 8'h01);
    expect_flag("R12 foreign release ignored", L, 12'h000, 8'h00);
    sem_write(R, 12'h000, 8'h00);
    expect_flag("R12 foreign request does not steal", L, 12'h000, 8'h00);
    sem_write(R, 12'h000, 8'h01);
    sem_write(L, 12'h000, 8'h01);
    expect_flag("R12 cleanup free", R, 12'h000, 8'hFF);
  endtask

  task automatic t_simul;
    @(negedge clk);
    drive(L, 1, 1, 0, 12'h006, 8'h00);
    drive(R, 1, 1, 0, 12'h006, 8'h00);
    @(negedge clk);
    drive(L, 0, 0, 0, '0, '0);
    drive(R, 0, 0, 0, '0, '0);
    expect_flag("R8 left wins tie", L, 12'h006, 8'h00);
    expect_flag("R8 right loses tie", R, 12'h006, 8'hFF);
    sem_write(L, 12'h006, 8'h01);
    expect_flag("R8 right request kept pending", R, 12'h006, 8'h00);
    sem_write(R, 12'h006, 8'h01);
  endtask

  task automatic t_freeze;
    sem_write(R, 12'h004, 8'h00);
    sem_write(L, 12'h004, 8'h00);
    @(negedge clk) drive(L, 1, 0, 1, 12'h004, 8'h00);
    @(negedge clk);
    chk("R9 first capture", l_rdata, 8'hFF);
    drive(R, 1, 1, 0, 12'h004, 8'h01);
    @(negedge clk);
    drive(R, 0, 0, 0, '0, '0);
    chk("R9 held read frozen", l_rdata, 8'hFF);
    @(negedge clk);
    chk("R9 still frozen", l_rdata, 8'hFF);
    chk("R9 valid while held", {7'd0, l_rvalid}, 8'h01);
    drive(L, 0, 0, 0, '0, '0);
    @(negedge clk);
    chk("R10 idle after read", l_rdata, 8'hFF);
    chk("R10 valid low after read", {7'd0, l_rvalid}, 8'h00);
    expect_flag("R9 fresh read sees new owner", L, 12'h004, 8'h00);
    sem_write(L, 12'h004, 8'h01);
  endtask

  task automatic t_write_not_read;
    sem_write(R, 12'h003, 8'h00);
    @(negedge clk) drive(R, 1, 1, 1, 12'h003, 8'h00);
    @(negedge clk);
    chk("R10 write cycle not a read (valid)", {7'd0, r_rvalid}, 8'h00);
    chk("R10 write cycle not a read (data)", r_rdata, 8'hFF);
    drive(R, 0, 0, 0, '0, '0);
    sem_write(R, 12'h003, 8'h01);
  endtask

  task automatic t_init;
    sem_write(L, 12'h003, 8'h00);
    sem_write(R, 12'h005, 8'h00);
    for (int i = 0; i < 8; i++) begin
      sem_write(L, 12'(i), 8'h01);
      sem_write(R, 12'(i), 8'h01);
    end
    for (int i = 0; i < 8; i++) begin
      expect_flag("R11 init frees left view", L, 12'(i), 8'hFF);
      expect_flag("R11 init frees right view", R, 12'(i), 8'hFF);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_claim();
    t_data_bits();
    t_handover();
    t_withdraw();
    t_keep();
    t_simul();
    t_freeze();
    t_write_not_read();
    t_init();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule